// File: doc/BRIEF.md
# Buffer Command Register Bank

This block is the control register file that a host reaches through the random-access port of a two-buffer sequential memory. The block is selected when the active-low command strobe is low and the chip enable is high. A read/write line and a three-bit register index, taken from the low host address bits, then choose a register. The bank holds a 12-bit start pointer and a 12-bit end pointer for each of two buffers. It also holds a stop-or-chain mode bit per buffer and an active-low end-of-buffer flag per buffer. The sequential pointer logic consumes all of these values directly.

The flags are special. The pointer logic pulls a flag low with a one-cycle hit pulse. The host reads the flags back from index 5. A host write to the same index clears flags, and each cleared flag also produces a one-cycle clear pulse for the pointer logic. An asynchronous reset forces the defaults at once. Its release is synchronized to the clock. The defaults are asymmetric: buffer 1 covers the full address range, buffer 2 is zeroed, both buffers chain, and both flags rest high.

Top module: `cmdreg_bank`

## Requirements
- R1: A host access takes place only when `cmd_n` is 0 and `chip_en` is 1. In every other case a write changes nothing, produces no clear pulse, and `rdata` is zero.
- R2: While `rst_n` is low, the outputs hold these defaults, applied asynchronously: buffer 1 start 0, buffer 1 end all ones (4095), buffer 2 start and end 0, `stop_mode` 00, `flag_n` 11, and `flag_clr` 00.
- R3: Index 0 holds the buffer 1 start, index 1 the buffer 1 end, index 2 the buffer 2 start and index 3 the buffer 2 end, all on data bits [11:0]. When `byte_en[0]` is 1 a write updates bits [7:0], and when `byte_en[1]` is 1 it updates bits [11:8].
- R4: Index 4 is the mode register. Bit 0 is buffer 1 and bit 1 is buffer 2, where 1 means stop and 0 means chain. The register is written only when `byte_en[0]` is 1, and it reads back on `rdata[1:0]`.
- R5: A write to index 5 with `byte_en[0]` set clears flags: data bit 0 returns `flag_n[0]` to 1 and data bit 1 returns `flag_n[1]` to 1. `flag_clr` carries the same bits for exactly one cycle after the write edge.
- R6: A read of index 5 returns `flag_n` on `rdata[1:0]`, with all other bits zero.
- R7: An `eob_hit` bit drives the matching `flag_n` bit to 0 at the next edge. If a hit and a clear of the same flag arrive in the same cycle, the flag goes to 0 and the clear pulse is still issued.
- R8: Indices 6 and 7 are reserved. Reads of them return zero and writes to them change nothing.
- R9: Host address bits above bit 2 and data bits 15:12 are ignored, and `rdata[15:12]` is always zero.
- R10: A write takes effect at the clock edge on which it is sampled. Read data is combinational and valid in the same cycle as the read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_n | input | 1 | Active-low command strobe |
| chip_en | input | 1 | Chip enable; must be 1 to reach the bank |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| haddr | input | 12 | Host address; bits [2:0] select the register |
| byte_en | input | 2 | Byte enables: bit 0 lower byte, bit 1 upper byte |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data (zero when no read access) |
| eob_hit | input | 2 | One-cycle end-of-buffer hit per buffer from the pointer logic |
| buf1_start | output | 12 | Buffer 1 start pointer |
| buf1_end | output | 12 | Buffer 1 end pointer |
| buf2_start | output | 12 | Buffer 2 start pointer |
| buf2_end | output | 12 | Buffer 2 end pointer |
| stop_mode | output | 2 | Per-buffer mode, 1 = stop, 0 = chain |
| flag_n | output | 2 | Active-low end-of-buffer flags |
| flag_clr | output | 2 | One-cycle flag clear pulses to the pointer logic |

## Verification
Every register is wired straight to an output port. A write that lands in the wrong register, updates the wrong byte lane, or leaks through while the bank is deselected is therefore visible on the pointer or mode outputs one edge after the write. The same fault is also visible at once on a combinational readback. A wrong flag priority or a lost clear shows up on `flag_n` at the edge after the hit or the clear. A missing, stretched or spurious clear pulse shows up on `flag_clr` in the cycle that follows.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

  localparam int SEL_W      = 3;
  localparam int NUM_SEL    = 2 ** SEL_W;
  localparam int NUM_PTR    = 4;
  localparam int NUM_BUF    = 2;
  localparam int LO_BYTE_W  = 8;

  typedef enum logic [SEL_W-1:0] {
    SEL_B1_START = 3'd0,
    SEL_B1_END   = 3'd1,
    SEL_B2_START = 3'd2,
    SEL_B2_END   = 3'd3,
    SEL_FLOW     = 3'd4,
    SEL_FLAG     = 3'd5,
    SEL_RSV6     = 3'd6,
    SEL_RSV7     = 3'd7
  } cmd_sel_e;

  // Only the buffer 1 end pointer comes out of reset as all ones.
  function automatic bit ptr_rst_ones(int idx);
    return idx == int'(SEL_B1_END);
  endfunction

endpackage

// File: rtl/cmdreg_rst_sync.sv
module cmdreg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_s_n <= stage_q;
    end
  end
endmodule

// File: rtl/cmdreg_decode.sv
module cmdreg_decode
  import cmdreg_pkg::*;
#(
  parameter int HADDR_W = 12
) (
  input  logic               cmd_n,
  input  logic               chip_en,
  input  logic               rd_wr_n,
  input  logic [HADDR_W-1:0] haddr,
  output logic               acc_rd,
  output logic               acc_wr,
  output cmd_sel_e           sel,
  output logic [NUM_SEL-1:0] wr_sel
);
  logic bank_sel;
  logic unused_haddr_hi;

  assign unused_haddr_hi = ^haddr[HADDR_W-1:SEL_W];

  always_comb begin
    bank_sel = !cmd_n && chip_en;
    acc_rd   = bank_sel && rd_wr_n;
    acc_wr   = bank_sel && !rd_wr_n;
    sel      = cmd_sel_e'(haddr[SEL_W-1:0]);
  end

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_wsel
    assign wr_sel[i] = acc_wr && (haddr[SEL_W-1:0] == SEL_W'(i));
  end
endmodule

// File: rtl/cmdreg_addr_reg.sv
module cmdreg_addr_reg #(
  parameter int            AW      = 12,
  parameter logic [AW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    byte_en,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] q
);
  localparam int LO_W = 8;
  localparam int HI_W = AW - LO_W;

  logic [AW-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (byte_en[0]) q_nxt[LO_W-1:0]          = wdata[LO_W-1:0];
    if (byte_en[1]) q_nxt[LO_W+HI_W-1:LO_W]  = wdata[LO_W+HI_W-1:LO_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= q_nxt;
  end
endmodule

// File: rtl/cmdreg_flow_flags.sv
module cmdreg_flow_flags #(
  parameter int NBUF = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flow_wr,
  input  logic            clr_wr,
  input  logic            lo_en,
  input  logic [NBUF-1:0] wbits,
  input  logic [NBUF-1:0] eob_hit,
  output logic [NBUF-1:0] stop_mode,
  output logic [NBUF-1:0] flag_n,
  output logic [NBUF-1:0] flag_clr
);
  logic [NBUF-1:0] stop_nxt;
  logic [NBUF-1:0] flag_nxt;
  logic [NBUF-1:0] clr_req;
  logic            flow_en;

  always_comb begin
    flow_en = flow_wr && lo_en;
    for (int b = 0; b < NBUF; b++) begin
      stop_nxt[b] = flow_en ? wbits[b] : stop_mode[b];
      clr_req[b]  = clr_wr && lo_en && wbits[b];
      // A hit in the same cycle as a clear wins: the event is not lost.
      if (eob_hit[b])      flag_nxt[b] = 1'b0;
      else if (clr_req[b]) flag_nxt[b] = 1'b1;
      else                 flag_nxt[b] = flag_n[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_mode <= '0;
      flag_n    <= '1;
      flag_clr  <= '0;
    end else begin
      if (flow_en) stop_mode <= stop_nxt;
      flag_n   <= flag_nxt;
      flag_clr <= clr_req;
    end
  end
endmodule

// File: rtl/cmdreg_bank.sv
module cmdreg_bank
  import cmdreg_pkg::*;
#(
  parameter int AW      = 12,
  parameter int BUS_W   = 16,
  parameter int HADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_n,
  input  logic               chip_en,
  input  logic               rd_wr_n,
  input  logic [HADDR_W-1:0] haddr,
  input  logic [1:0]         byte_en,
  input  logic [BUS_W-1:0]   wdata,
  output logic [BUS_W-1:0]   rdata,
  input  logic [NUM_BUF-1:0] eob_hit,
  output logic [AW-1:0]      buf1_start,
  output logic [AW-1:0]      buf1_end,
  output logic [AW-1:0]      buf2_start,
  output logic [AW-1:0]      buf2_end,
  output logic [NUM_BUF-1:0] stop_mode,
  output logic [NUM_BUF-1:0] flag_n,
  output logic [NUM_BUF-1:0] flag_clr
);
  logic               rst_s_n;
  logic               acc_rd;
  logic               acc_wr;
  cmd_sel_e           sel;
  logic [NUM_SEL-1:0] wr_sel;
  logic [AW-1:0]      ptr_q [NUM_PTR];
  logic [BUS_W-1:0]   rdata_c;
  logic               unused_bits;

  assign unused_bits = ^{wr_sel[NUM_SEL-1:NUM_PTR+2], wdata[BUS_W-1:AW], acc_wr};

  cmdreg_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  cmdreg_decode #(.HADDR_W(HADDR_W)) u_dec (
    .cmd_n   (cmd_n),
    .chip_en (chip_en),
    .rd_wr_n (rd_wr_n),
    .haddr   (haddr),
    .acc_rd  (acc_rd),
    .acc_wr  (acc_wr),
    .sel     (sel),
    .wr_sel  (wr_sel)
  );

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    localparam logic [AW-1:0] RV = ptr_rst_ones(i) ? {AW{1'b1}} : '0;
    cmdreg_addr_reg #(.AW(AW), .RST_VAL(RV)) u_reg (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .wr_en   (wr_sel[i]),
      .byte_en (byte_en),
      .wdata   (wdata[AW-1:0]),
      .q       (ptr_q[i])
    );
  end

  cmdreg_flow_flags #(.NBUF(NUM_BUF)) u_ff (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .flow_wr   (wr_sel[int'(SEL_FLOW)]),
    .clr_wr    (wr_sel[int'(SEL_FLAG)]),
    .lo_en     (byte_en[0]),
    .wbits     (wdata[NUM_BUF-1:0]),
    .eob_hit   (eob_hit),
    .stop_mode (stop_mode),
    .flag_n    (flag_n),
    .flag_clr  (flag_clr)
  );

  always_comb begin
    rdata_c = '0;
    if (acc_rd) begin
      unique case (sel)
        SEL_B1_START: rdata_c[AW-1:0]      = ptr_q[0];
        SEL_B1_END:   rdata_c[AW-1:0]      = ptr_q[1];
        SEL_B2_START: rdata_c[AW-1:0]      = ptr_q[2];
        SEL_B2_END:   rdata_c[AW-1:0]      = ptr_q[3];
        SEL_FLOW:     rdata_c[NUM_BUF-1:0] = stop_mode;
        SEL_FLAG:     rdata_c[NUM_BUF-1:0] = flag_n;
        default:      rdata_c              = '0;
      endcase
    end
  end

  assign rdata      = rdata_c;
  assign buf1_start = ptr_q[0];
  assign buf1_end   = ptr_q[1];
  assign buf2_start = ptr_q[2];
  assign buf2_end   = ptr_q[3];
endmodule

// File: rtl/cmdreg_bank_chk.sv
module cmdreg_bank_chk #(
  parameter int AW      = 12,
  parameter int BUS_W   = 16,
  parameter int HADDR_W = 12
) (
  input logic               clk,
  input logic               rst_s_n,
  input logic               cmd_n,
  input logic               chip_en,
  input logic               rd_wr_n,
  input logic [HADDR_W-1:0] haddr,
  input logic               byte_lo,
  input logic [BUS_W-1:0]   wdata,
  input logic [BUS_W-1:0]   rdata,
  input logic [1:0]         eob_hit,
  input logic [AW-1:0]      buf1_start,
  input logic [AW-1:0]      buf1_end,
  input logic [AW-1:0]      buf2_start,
  input logic [AW-1:0]      buf2_end,
  input logic [1:0]         stop_mode,
  input logic [1:0]         flag_n,
  input logic [1:0]         flag_clr
);
  logic bank_on;
  logic rsv_wr;
  logic clr_wr;
  assign bank_on = !cmd_n && chip_en;
  assign rsv_wr  = bank_on && !rd_wr_n && (haddr[2:1] == 2'b11);
  assign clr_wr  = bank_on && !rd_wr_n && (haddr[2:0] == 3'b101) && byte_lo;

  a_r1_deselect_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    !bank_on |=> $stable({buf1_start, buf1_end, buf2_start, buf2_end, stop_mode}));

  a_r1_rdata_idle_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(bank_on && rd_wr_n) |-> (rdata == '0));

  a_r5_clr_from_write: assert property (@(posedge clk) disable iff (!rst_s_n)
    (flag_clr != 2'b00) |-> $past(clr_wr && ((wdata[1:0] & flag_clr) == flag_clr)));

  a_r7_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_s_n)
    (eob_hit != 2'b00) |=> ((flag_n & $past(eob_hit)) == 2'b00));

  a_r8_reserved_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    rsv_wr |=> $stable({buf1_start, buf1_end, buf2_start, buf2_end, stop_mode}));

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_s_n)
    rdata[BUS_W-1:AW] == '0);
endmodule

bind cmdreg_bank cmdreg_bank_chk #(.AW(AW), .BUS_W(BUS_W), .HADDR_W(HADDR_W)) chk_i (
  .clk        (clk),
  .rst_s_n    (rst_s_n),
  .cmd_n      (cmd_n),
  .chip_en    (chip_en),
  .rd_wr_n    (rd_wr_n),
  .haddr      (haddr),
  .byte_lo    (byte_en[0]),
  .wdata      (wdata),
  .rdata      (rdata),
  .eob_hit    (eob_hit),
  .buf1_start (buf1_start),
  .buf1_end   (buf1_end),
  .buf2_start (buf2_start),
  .buf2_end   (buf2_end),
  .stop_mode  (stop_mode),
  .flag_n     (flag_n),
  .flag_clr   (flag_clr)
);

// File: tb/cmdreg_bank_tb_top.sv
module cmdreg_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 12;
  localparam int BUS_W      = 16;
  localparam int HADDR_W    = 12;

  logic               clk;
  logic               rst_n;
  logic               cmd_n;
  logic               chip_en;
  logic               rd_wr_n;
  logic [HADDR_W-1:0] haddr;
  logic [1:0]         byte_en;
  logic [BUS_W-1:0]   wdata;
  logic [BUS_W-1:0]   rdata;
  logic [1:0]         eob_hit;
  logic [AW-1:0]      buf1_start, buf1_end, buf2_start, buf2_end;
  logic [1:0]         stop_mode, flag_n, flag_clr;

  cmdreg_bank #(.AW(AW), .BUS_W(BUS_W), .HADDR_W(HADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .chip_en(chip_en), .rd_wr_n(rd_wr_n),
    .haddr(haddr), .byte_en(byte_en), .wdata(wdata), .rdata(rdata), .eob_hit(eob_hit),
    .buf1_start(buf1_start), .buf1_end(buf1_end), .buf2_start(buf2_start),
    .buf2_end(buf2_end), .stop_mode(stop_mode), .flag_n(flag_n), .flag_clr(flag_clr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [AW-1:0] m_ptr [4];
  logic [1:0]    m_stop;
  logic [1:0]    m_flag;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic model_reset();
    m_ptr[0] = '0; m_ptr[1] = '1; m_ptr[2] = '0; m_ptr[3] = '0;
    m_stop = 2'b00; m_flag = 2'b11;
  endtask

  function automatic logic [BUS_W-1:0] exp_rd(int a);
    case (a)
      0, 1, 2, 3: return {4'h0, m_ptr[a]};
      4:          return {14'h0, m_stop};
      5:          return {14'h0, m_flag};
      default:    return '0;
    endcase
  endfunction

  task automatic go_idle();
    cmd_n = 1'b1; chip_en = 1'b0; rd_wr_n = 1'b1;
    haddr = '0; byte_en = 2'b00; wdata = '0;
  endtask

  task automatic wr(logic [HADDR_W-1:0] a, logic [1:0] be, logic [BUS_W-1:0] d);
    @(negedge clk);
    cmd_n = 1'b0; chip_en = 1'b1; rd_wr_n = 1'b0; haddr = a; byte_en = be; wdata = d;
    @(negedge clk);
    go_idle();
  endtask

  task automatic rd_chk(string req, logic [HADDR_W-1:0] a);
    @(negedge clk);
    cmd_n = 1'b0; chip_en = 1'b1; rd_wr_n = 1'b1; haddr = a; byte_en = 2'b11;
    #1;
    chk(req, 32'(rdata), 32'(exp_rd(int'(a[2:0]))));
    go_idle();
  endtask

  task automatic chk_side(string req);
    chk({req, " b1s"}, 32'(buf1_start), 32'(m_ptr[0]));
    chk({req, " b1e"}, 32'(buf1_end),   32'(m_ptr[1]));
    chk({req, " b2s"}, 32'(buf2_start), 32'(m_ptr[2]));
    chk({req, " b2e"}, 32'(buf2_end),   32'(m_ptr[3]));
    chk({req, " stop"}, 32'(stop_mode), 32'(m_stop));
    chk({req, " flag"}, 32'(flag_n),    32'(m_flag));
  endtask

  task automatic hit(logic [1:0] h);
    @(negedge clk); eob_hit = h;
    @(negedge clk); eob_hit = 2'b00;
    m_flag = m_flag & ~h;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; eob_hit = 2'b00; go_idle();
    #1 rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    chk_side("R2 in reset");
    chk("R2 clr", 32'(flag_clr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_side("R2 after release");
    for (int a = 0; a < 8; a++) rd_chk(a < 6 ? "R2 readback" : "R8 read", HADDR_W'(a));

    // R3 / R9 / R10: pointer registers, every byte-enable combination, junk upper bits
    for (int r = 0; r < 4; r++) begin
      for (int be = 0; be < 4; be++) begin
        logic [AW-1:0] pat;
        logic [AW-1:0] mask;
        pat  = AW'(r * 12'h3A7 + be * 12'h5B1 + 12'h123);
        mask = {(be[1] ? 4'hF : 4'h0), (be[0] ? 8'hFF : 8'h00)};
        wr({9'((r + be) * 37 + 1), 3'(r)}, 2'(be), {4'hF, pat});
        m_ptr[r] = (m_ptr[r] & ~mask) | (pat & mask);
        chk_side("R3 R10 byte write");
        rd_chk("R3 R9 readback", {9'((r * 5 + be) * 11), 3'(r)});
      end
    end

    // R4: mode register
    for (int v = 0; v < 4; v++) begin
      wr(HADDR_W'(4), 2'b01, {14'h3FF0, 2'(v)});
      m_stop = 2'(v);
      chk_side("R4 mode write");
      rd_chk("R4 mode read", HADDR_W'(4));
    end
    wr(HADDR_W'(4), 2'b10, 16'h0001);
    chk_side("R4 upper lane ignored");

    // R7 / R6: hits pull flags low, status read
    hit(2'b01);
    chk_side("R7 hit flag1");
    rd_chk("R6 status", HADDR_W'(5));
    hit(2'b10);
    chk_side("R7 hit flag2");
    rd_chk("R6 status", HADDR_W'(5));

    // R5: clear patterns and pulse width
    for (int c = 0; c < 4; c++) begin
      hit(2'b11);
      wr(HADDR_W'(5), 2'b01, {14'h0, 2'(c)});
      m_flag = m_flag | 2'(c);
      chk("R5 pulse", 32'(flag_clr), 32'(c));
      chk_side("R5 clear");
      rd_chk("R6 after clear", HADDR_W'(5));
      @(negedge clk);
      chk("R5 pulse one cycle", 32'(flag_clr), 0);
    end
    hit(2'b11);
    wr(HADDR_W'(5), 2'b10, 16'h0003);
    chk("R5 no lower lane no pulse", 32'(flag_clr), 0);
    chk_side("R5 no lower lane");

    // R7: hit and clear together
    @(negedge clk);
    cmd_n = 1'b0; chip_en = 1'b1; rd_wr_n = 1'b0; haddr = HADDR_W'(5);
    byte_en = 2'b01; wdata = 16'h0003; eob_hit = 2'b01;
    @(negedge clk);
    go_idle(); eob_hit = 2'b00;
    m_flag = 2'b10;
    chk("R7 pulse kept", 32'(flag_clr), 3);
    chk_side("R7 hit wins");

    // R8: reserved writes
    wr(HADDR_W'(6), 2'b11, 16'hFFFF);
    wr(HADDR_W'(7), 2'b11, 16'hFFFF);
    chk_side("R8 reserved write");
    rd_chk("R8 read6", HADDR_W'(6));
    rd_chk("R8 read7", HADDR_W'(7));

    // R1: deselected accesses
    for (int mode = 0; mode < 3; mode++) begin
      for (int a = 0; a < 6; a++) begin
        @(negedge clk);
        cmd_n = (mode != 0); chip_en = (mode == 1); rd_wr_n = 1'b0;
        haddr = HADDR_W'(a); byte_en = 2'b11; wdata = 16'h0A5F ^ 16'(a * 16'h0111);
        @(negedge clk);
        chk("R1 no pulse", 32'(flag_clr), 0);
        rd_wr_n = 1'b1;
        #1;
        chk("R1 read zero", 32'(rdata), 0);
        go_idle();
      end
      chk_side("R1 deselect");
    end

    // R2: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_reset();
    chk_side("R2 async");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk("R2 end default", HADDR_W'(1));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule